// File: doc/BRIEF.md
# Phase-Error Lock Detector

This block decides, once per phase-detector comparison, whether a phase-locked loop is in lock. It works entirely in the domain of a fast sampling clock. It receives two single-cycle edge pulses that have already been synchronized into that domain: one marks a reference-clock edge and the other a feedback-clock edge. The first pulse of a pair opens a measurement window. The window closes when a pulse of the other kind arrives, and the number of sampling ticks in between is taken as the phase error. Either pulse may lead.

Each completed comparison is judged against two thresholds, both given in ticks as parameters. A wide one flags a large phase transient as loss of lock. A tighter window must then hold for a run of consecutive comparisons before lock counts as qualified. A reference-switch sequencer uses the falling edge of lock as its trigger and the qualified level as the signal to end its narrow-bandwidth phase.

Two conditions are treated as out of lock because a partner edge has gone missing. One is a window that stays open longer than the timeout. The other is a second pulse of the kind that opened the window, arriving before any partner. Both conditions are also reported on a pulse of their own.

Top module: `phase_lock_detector`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `cyc_lock`, `qual_lock`, `lol_pulse` and `edge_missing` are all 0.
- R2: The phase error of a comparison is the number of rising `clk` edges from the sample of the opening pulse to the sample of the closing pulse. A reference pulse and a feedback pulse sampled in the same cycle, with no window open, form a comparison with error 0.
- R3: Each comparison drives `cyc_lock` to 1 when its error is below `LOL_TICKS` and to 0 otherwise. The new value is visible two rising edges after the closing pulse is sampled. Between comparisons `cyc_lock` holds its value, so it may toggle from one comparison to the next.
- R4: `lol_pulse` is high for exactly one cycle, in the same cycle that `cyc_lock` changes from 1 to 0. A comparison that leaves `cyc_lock` at 0 gives no pulse.
- R5: `qual_lock` rises on the update of the comparison that completes `QUAL_CYCLES` consecutive comparisons with error at most `WIN_TICKS`. It stays high while further comparisons remain inside that window.
- R6: Any comparison with error above `WIN_TICKS` clears the consecutive count and `qual_lock`. This holds even when the error is still below `LOL_TICKS` and `cyc_lock` stays 1.
- R7: If no partner pulse is sampled within `TIMEOUT_TICKS` edges after the opening pulse, the window closes as a missed comparison. That update sets `cyc_lock` to 0, clears the qualification and raises `edge_missing` for one cycle, `TIMEOUT_TICKS + 1` edges after the opening pulse was sampled.
- R8: A second pulse of the same kind as the opener, sampled before any partner, ends the open comparison as a miss (same outputs as R7, two edges later). It then opens a new window from that second pulse.
- R9: A comparison opened by a feedback pulse is judged in the same way as one opened by a reference pulse with the same tick count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Single-cycle pulse per reference-clock edge, synchronized to clk |
| fb_pulse | input | 1 | Single-cycle pulse per feedback-clock edge, synchronized to clk |
| cyc_lock | output | 1 | Lock status from the most recent comparison |
| lol_pulse | output | 1 | One-cycle pulse when lock is lost |
| qual_lock | output | 1 | Level: the consecutive in-window run is complete |
| edge_missing | output | 1 | One-cycle pulse when a comparison ends without a partner edge |

## Verification
The block has two register stages, the measurement register and then the status register. A comparison that closes on the pulse sampled at edge N therefore shows its results just after edge N+1. A miss from a timeout shows just after edge O+TIMEOUT_TICKS+1, where O is the edge that sampled the opener.

The driver notes the cycle count at the falling edge where it places each closing pulse. It queues the expected status with a due cycle two counts later, and the monitor compares at that falling edge only. At every other falling edge the monitor checks that the level outputs still hold their last expected values and that neither pulse output is high.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_REF  = 2'd1,
    WIN_FB   = 2'd2
  } win_state_t;

  typedef struct packed {
    logic valid;
    logic miss;
  } meas_flags_t;

  typedef struct packed {
    logic far;
    logic inwin;
  } verdict_t;

endpackage

// File: rtl/edge_pair_meter.sv
module edge_pair_meter
  import lockdet_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 64,
  parameter int CNT_W         = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output meas_flags_t      flags,
  output logic [CNT_W-1:0] mag
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  win_state_t       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  meas_flags_t      flags_n;
  logic [CNT_W-1:0] mag_n;
  logic             opp, same;

  // partner / repeat pulse relative to the open window
  always_comb begin
    opp  = 1'b0;
    same = 1'b0;
    if (st == WIN_REF) begin
      opp  = fb_pulse;
      same = ref_pulse;
    end else if (st == WIN_FB) begin
      opp  = ref_pulse;
      same = fb_pulse;
    end
  end

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    flags_n = '0;
    mag_n   = '0;
    unique case (st)
      WIN_IDLE: begin
        if (ref_pulse && fb_pulse) begin
          flags_n.valid = 1'b1;
        end else if (ref_pulse) begin
          st_n  = WIN_REF;
          cnt_n = ONE;
        end else if (fb_pulse) begin
          st_n  = WIN_FB;
          cnt_n = ONE;
        end
      end
      WIN_REF, WIN_FB: begin
        if (opp) begin
          flags_n.valid = 1'b1;
          mag_n         = cnt;
          if (same) cnt_n = ONE;
          else      st_n  = WIN_IDLE;
        end else if (same) begin
          flags_n.valid = 1'b1;
          flags_n.miss  = 1'b1;
          mag_n         = cnt;
          cnt_n         = ONE;
        end else if (cnt >= LIMIT) begin
          flags_n.valid = 1'b1;
          flags_n.miss  = 1'b1;
          mag_n         = cnt;
          st_n          = WIN_IDLE;
        end else begin
          cnt_n = cnt + ONE;
        end
      end
      default: st_n = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= WIN_IDLE;
      cnt   <= '0;
      flags <= '0;
      mag   <= '0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      flags <= flags_n;
      mag   <= mag_n;
    end
  end

endmodule

// File: rtl/lock_classifier.sv
module lock_classifier
  import lockdet_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int LOL_TICKS = 8,
  parameter int WIN_TICKS = 4
) (
  input  meas_flags_t      flags,
  input  logic [CNT_W-1:0] mag,
  output verdict_t         verdict
);

  int unsigned mag_i;

  always_comb begin
    mag_i         = {{(32-CNT_W){1'b0}}, mag};
    verdict.far   = flags.miss || (mag_i >= LOL_TICKS);
    verdict.inwin = !flags.miss && (mag_i <= WIN_TICKS);
  end

endmodule

// File: rtl/lock_state.sv
module lock_state
  import lockdet_pkg::*;
#(
  parameter int QUAL_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  meas_flags_t flags,
  input  verdict_t    verdict,
  output logic        cyc_lock,
  output logic        lol_pulse,
  output logic        qual_lock,
  output logic        edge_missing
);

  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

  logic [QW-1:0] qcnt, qnext;

  always_comb begin
    qnext = (qcnt >= QMAX) ? QMAX : qcnt + QW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_lock     <= 1'b0;
      lol_pulse    <= 1'b0;
      qual_lock    <= 1'b0;
      edge_missing <= 1'b0;
      qcnt         <= '0;
    end else begin
      lol_pulse    <= 1'b0;
      edge_missing <= 1'b0;
      if (flags.valid) begin
        cyc_lock     <= !verdict.far;
        lol_pulse    <= cyc_lock && verdict.far;
        edge_missing <= flags.miss;
        if (verdict.inwin) begin
          qcnt      <= qnext;
          qual_lock <= (qnext == QMAX);
        end else begin
          qcnt      <= '0;
          qual_lock <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
  import lockdet_pkg::*;
#(
  parameter int LOL_TICKS     = 8,
  parameter int WIN_TICKS     = 4,
  parameter int QUAL_CYCLES   = 8,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic cyc_lock,
  output logic lol_pulse,
  output logic qual_lock,
  output logic edge_missing
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);

  meas_flags_t      m_flags;
  logic [CNT_W-1:0] m_mag;
  verdict_t         m_verdict;

  edge_pair_meter #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .CNT_W        (CNT_W)
  ) u_meter (
    .clk      (clk),
    .rst      (rst),
    .ref_pulse(ref_pulse),
    .fb_pulse (fb_pulse),
    .flags    (m_flags),
    .mag      (m_mag)
  );

  lock_classifier #(
    .CNT_W    (CNT_W),
    .LOL_TICKS(LOL_TICKS),
    .WIN_TICKS(WIN_TICKS)
  ) u_class (
    .flags  (m_flags),
    .mag    (m_mag),
    .verdict(m_verdict)
  );

  lock_state #(
    .QUAL_CYCLES(QUAL_CYCLES)
  ) u_state (
    .clk         (clk),
    .rst         (rst),
    .flags       (m_flags),
    .verdict     (m_verdict),
    .cyc_lock    (cyc_lock),
    .lol_pulse   (lol_pulse),
    .qual_lock   (qual_lock),
    .edge_missing(edge_missing)
  );

endmodule

// File: rtl/phase_lock_detector_chk.sv
module phase_lock_detector_chk (
  input logic clk,
  input logic rst,
  input logic meas_vld,
  input logic cyc_lock,
  input logic lol_pulse,
  input logic qual_lock,
  input logic edge_missing
);

  // R1: outputs come out of reset cleared
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cyc_lock && !qual_lock && !lol_pulse && !edge_missing));

  // R3: status only moves after a measurement was registered
  a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
    !$past(meas_vld) |-> $stable(cyc_lock));

  // R4: loss of lock is announced exactly on the falling edge of lock
  a_r4_pulse_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(cyc_lock) |-> lol_pulse);

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
    lol_pulse |=> !lol_pulse);

  // R5: qualification lies inside the lock range
  a_r5_qual_in_lock: assert property (@(posedge clk) disable iff (rst)
    qual_lock |-> cyc_lock);

  // R7: a missing edge always reads as out of lock
  a_r7_miss_unlocked: assert property (@(posedge clk) disable iff (rst)
    edge_missing |-> (!cyc_lock && !qual_lock));

endmodule

bind phase_lock_detector phase_lock_detector_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .meas_vld    (m_flags.valid),
  .cyc_lock    (cyc_lock),
  .lol_pulse   (lol_pulse),
  .qual_lock   (qual_lock),
  .edge_missing(edge_missing)
);

// File: tb/test_phase_lock_detector.sv
`timescale 1ns/1ps
module test_phase_lock_detector;

  localparam int LOL  = 8;
  localparam int WIN  = 4;
  localparam int QUAL = 8;
  localparam int TMO  = 64;
  localparam int WATCHDOG = 20000;

  typedef struct {
    int    due;
    bit    lock;
    bit    qual;
    bit    lol;
    bit    miss;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_pulse = 1'b0;
  logic fb_pulse  = 1'b0;
  logic cyc_lock, lol_pulse, qual_lock, edge_missing;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];

  bit   m_lock = 1'b0;
  int   m_qcnt = 0;
  bit   mon_lock = 1'b0;
  bit   mon_qual = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  phase_lock_detector #(
    .LOL_TICKS(LOL), .WIN_TICKS(WIN), .QUAL_CYCLES(QUAL), .TIMEOUT_TICKS(TMO)
  ) i_phase_lock_detector (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .cyc_lock(cyc_lock), .lol_pulse(lol_pulse), .qual_lock(qual_lock),
    .edge_missing(edge_missing)
  );

  task automatic check_bit(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // bench model of the requirements, pushes one expected item
  task automatic record(int mag, bit miss, int due, string tag);
    exp_t e;
    bit nl, inw;
    nl  = !miss && (mag < LOL);
    inw = !miss && (mag <= WIN);
    if (inw) m_qcnt = (m_qcnt >= QUAL) ? QUAL : m_qcnt + 1;
    else     m_qcnt = 0;
    e.due  = due;
    e.lock = nl;
    e.qual = (m_qcnt == QUAL);
    e.lol  = m_lock && !nl;
    e.miss = miss;
    e.tag  = tag;
    m_lock = nl;
    q.push_back(e);
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic pulse(bit r, bit f, output int c);
    ref_pulse = r;
    fb_pulse  = f;
    c = cyc;
    @(negedge clk);
    ref_pulse = 1'b0;
    fb_pulse  = 1'b0;
  endtask

  task automatic compare(bit ref_leads, int gap, string tag);
    int c;
    if (gap == 0) begin
      pulse(1'b1, 1'b1, c);
    end else begin
      pulse(ref_leads, !ref_leads, c);
      repeat (gap - 1) @(negedge clk);
      pulse(!ref_leads, ref_leads, c);
    end
    record(gap, 1'b0, c + 2, tag);
    repeat (3) @(negedge clk);
  endtask

  task automatic lone_edge(bit use_ref, string tag);
    int c;
    pulse(use_ref, !use_ref, c);
    record(TMO, 1'b1, c + 2 + TMO, tag);
    repeat (TMO + 4) @(negedge clk);
  endtask

  // opener, repeat of the same kind after g, partner h after the repeat
  task automatic repeat_edge(bit ref_leads, int g, int h, string tag);
    int c;
    pulse(ref_leads, !ref_leads, c);
    repeat (g - 1) @(negedge clk);
    pulse(ref_leads, !ref_leads, c);
    record(g, 1'b1, c + 2, tag);
    repeat (h - 1) @(negedge clk);
    pulse(!ref_leads, ref_leads, c);
    record(h, 1'b0, c + 2, tag);
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares each expected item on its due cycle
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (q.size() > 0 && q[0].due < cyc) begin
        errors++;
        $display("FAIL %s result missed: actual none expected at cycle %0d", q[0].tag, q[0].due);
        void'(q.pop_front());
      end else if (q.size() > 0 && q[0].due == cyc) begin
        check_bit(q[0].tag, "cyc_lock", cyc_lock, q[0].lock);
        check_bit(q[0].tag, "qual_lock", qual_lock, q[0].qual);
        check_bit(q[0].tag, "lol_pulse", lol_pulse, q[0].lol);
        check_bit(q[0].tag, "edge_missing", edge_missing, q[0].miss);
        mon_lock = q[0].lock;
        mon_qual = q[0].qual;
        void'(q.pop_front());
      end else begin
        check_bit("R3", "cyc_lock hold", cyc_lock, mon_lock);
        check_bit("R5", "qual_lock hold", qual_lock, mon_qual);
        check_bit("R4", "idle lol_pulse", lol_pulse, 1'b0);
        check_bit("R7", "idle edge_missing", edge_missing, 1'b0);
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc >= WATCHDOG) begin
      errors++;
      $display("FAIL R3 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    check_bit("R1", "cyc_lock in reset", cyc_lock, 1'b0);
    check_bit("R1", "qual_lock in reset", qual_lock, 1'b0);
    check_bit("R1", "lol_pulse in reset", lol_pulse, 1'b0);
    check_bit("R1", "edge_missing in reset", edge_missing, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1'b1;

    // R5: seven in-window comparisons stay unqualified, the eighth qualifies
    for (int i = 0; i < QUAL; i++) compare(1'b1, 2, "R5");
    // R6: error between window and trip point keeps lock, drops qualification
    compare(1'b1, 6, "R6");
    // R4/R9: feedback-led error at the trip point loses lock with a pulse
    compare(1'b0, LOL, "R4");
    // R4: already out of lock, no second pulse
    compare(1'b1, LOL + 1, "R4");
    // R3/R9: one tick below the trip point, feedback leading
    compare(1'b0, LOL - 1, "R3");
    // R2/R9: same-cycle edges and the window edge, leads alternating
    for (int i = 0; i < QUAL; i++) begin
      if (i % 3 == 0)      compare(1'b1, 0, "R2");
      else if (i % 3 == 1) compare(1'b0, WIN, "R9");
      else                 compare(1'b1, WIN, "R2");
    end
    // R5: qualification holds on a further in-window comparison
    compare(1'b0, 1, "R5");
    // R7: lone reference edge times out
    lone_edge(1'b1, "R7");
    compare(1'b1, 3, "R3");
    // R7: lone feedback edge times out
    lone_edge(1'b0, "R7");
    // R8: repeated opener ends the comparison, then the new window measures
    compare(1'b1, 1, "R3");
    repeat_edge(1'b1, 5, 3, "R8");
    repeat_edge(1'b0, 2, 6, "R8");

    repeat (5) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R3 pending results: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule